// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is the sequencing core of a bus-master DMA engine. Software builds a table of 8-byte region descriptors in memory, gives the engine the table's address and a direction, and raises a run command. The engine then fetches each descriptor over a simple read port. It checks the region and moves the region's bytes as DWord beats over a ready/valid port toward a line buffer. The beats flow either from the disk side into memory or from memory toward the disk. It stops when the region flagged as the last one has been fully moved.

Each descriptor is read as two 32-bit words. The first word carries the region's byte address. The second carries a 16-bit byte length in its low half and the end-of-table flag in bit 31. A length of zero stands for 65536 bytes. The table pointer steps by 8 inside its 64 KB window. A region that would run past a 64 KB boundary stops the walk with an error. Dropping the run command at any time returns the engine to idle.

Top module: `sg_dma_walker`

## Requirements
- R1: After reset, busy, done, err, desc_rd_req and xfer_valid are all low.
- R2: A rising edge of cmd_go while idle raises busy on the next clock and fetches the first descriptor at tbl_base with bits 2:0 cleared. The address word is read first and the length/flag word at that address plus 4 is read second; each read completes on a cycle where desc_rd_ack is high.
- R3: After a region that is not the last, the next descriptor is fetched 8 bytes further on. The low 16 bits of the table address wrap and the upper 16 bits do not change.
- R4: Bits 1:0 of the region address word are ignored. Beats start at the DWord-aligned address and advance by 4 per accepted beat (xfer_valid and xfer_ready both high).
- R5: Bits 15:0 of the second word give the region length in bytes, with 0 meaning 65536. Every beat carries xfer_bytes = 4 except the region's last beat, which carries the remainder (1 to 4).
- R6: When bit 31 of the second word is set, the walk ends after that region's last beat: busy falls and done rises on the same clock. done and err are cleared by the next start.
- R7: If the aligned region address's low 16 bits plus the length exceed 65536, err rises, busy falls and no beat of that region is offered. A region ending exactly on the boundary is accepted.
- R8: cmd_go low while busy forces idle on the next clock without setting done, and drops desc_rd_req and xfer_valid.
- R9: xfer_write equals cmd_to_mem as sampled at the start and holds for the whole walk, whatever the input does later.
- R10: Holding cmd_go high after a walk ends starts nothing; only a new rising edge starts a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_go | input | 1 | Run command; rising edge starts, low aborts |
| cmd_to_mem | input | 1 | Direction: 1 moves disk data into memory |
| tbl_base | input | 32 | Byte address of the descriptor table |
| desc_rd_req | output | 1 | Descriptor word read request |
| desc_rd_addr | output | 32 | Descriptor word address |
| desc_rd_ack | input | 1 | Read data valid, completes the read |
| desc_rd_data | input | 32 | Descriptor word |
| xfer_valid | output | 1 | A data beat is offered |
| xfer_ready | input | 1 | Line buffer accepts the beat |
| xfer_addr | output | 32 | Memory byte address of the beat |
| xfer_bytes | output | 3 | Valid bytes in the beat, 1 to 4 |
| xfer_write | output | 1 | Beat direction, latched at start |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last region fully moved |
| err | output | 1 | Region would cross a 64 KB boundary |

## Verification
The hardest states to reach from the ports are the two window edges. One is a table pointer at offset 0xFFF8 that must wrap to offset 0 of the same 64 KB page. The other is a region that ends exactly on a boundary next to one that overruns it by a few bytes. The bench places descriptors at those offsets in its memory model and lays out table and region addresses by hand. A zero length field is run in full, 16384 beats, so the 65536-byte meaning is seen end to end. The abort case holds xfer_ready low so the engine is parked mid-region when the command drops.

// File: rtl/sg_dma_walker.sv
module sg_dma_walker #(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int WIN_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic          cmd_to_mem,
  input  logic [AW-1:0] tbl_base,
  output logic          desc_rd_req,
  output logic [AW-1:0] desc_rd_addr,
  input  logic          desc_rd_ack,
  input  logic [31:0]   desc_rd_data,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [AW-1:0] xfer_addr,
  output logic [2:0]    xfer_bytes,
  output logic          xfer_write,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int RW = LEN_W + 1;
  localparam logic [RW-1:0] FULL_LEN = RW'(1) << LEN_W;
  localparam logic [WIN_W+1:0] WIN_SIZE = (WIN_W+2)'(1) << WIN_W;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CNT, S_CHK, S_MOVE} st_t;

  st_t            st;
  logic           go_q, dir_q, eot_q, done_q, err_q;
  logic [AW-1:3]  ptr;
  logic [AW-1:0]  cur;
  logic [RW-1:0]  remain;
  logic           start, last, overrun;
  logic           unused_bits;

  assign start   = cmd_go && !go_q && st == S_IDLE;
  assign last    = remain <= RW'(4);
  assign overrun = ({2'b00, cur[WIN_W-1:0]} + (WIN_W+2)'(remain)) > WIN_SIZE;

  assign desc_rd_req  = st == S_ADDR || st == S_CNT;
  assign desc_rd_addr = {ptr, st == S_CNT, 2'b00};
  assign xfer_valid   = st == S_MOVE;
  assign xfer_addr    = cur;
  assign xfer_bytes   = last ? remain[2:0] : 3'd4;
  assign xfer_write   = dir_q;
  assign busy         = st != S_IDLE;
  assign done         = done_q;
  assign err          = err_q;
  assign unused_bits  = ^{desc_rd_data[30:LEN_W], desc_rd_data[1:0], tbl_base[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      go_q   <= 1'b0;
      dir_q  <= 1'b0;
      eot_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ptr    <= '0;
      cur    <= '0;
      remain <= '0;
    end else begin
      go_q <= cmd_go;
      if (!cmd_go && st != S_IDLE) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st     <= S_ADDR;
            ptr    <= tbl_base[AW-1:3];
            dir_q  <= cmd_to_mem;
            done_q <= 1'b0;
            err_q  <= 1'b0;
          end
          S_ADDR: if (desc_rd_ack) begin
            cur <= {desc_rd_data[AW-1:2], 2'b00};
            st  <= S_CNT;
          end
          S_CNT: if (desc_rd_ack) begin
            remain <= (desc_rd_data[LEN_W-1:0] == '0) ? FULL_LEN
                                                       : {1'b0, desc_rd_data[LEN_W-1:0]};
            eot_q  <= desc_rd_data[31];
            st     <= S_CHK;
          end
          S_CHK: begin
            if (overrun) begin
              err_q <= 1'b1;
              st    <= S_IDLE;
            end else begin
              st <= S_MOVE;
            end
          end
          S_MOVE: if (xfer_ready) begin
            if (last) begin
              if (eot_q) begin
                done_q <= 1'b1;
                st     <= S_IDLE;
              end else begin
                ptr <= {ptr[AW-1:WIN_W], ptr[WIN_W-1:3] + 1'b1};
                st  <= S_ADDR;
              end
            end else begin
              cur    <= cur + AW'(4);
              remain <= remain - RW'(4);
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !done && !err); // R1
  AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE && cmd_go && !go_q) |=> desc_rd_req && desc_rd_addr[2:0] == 3'b000); // R2
  AST_TABLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (st == S_ADDR && $past(st) == S_MOVE) |-> ptr[AW-1:WIN_W] == $past(ptr[AW-1:WIN_W])); // R3
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (xfer_valid && xfer_ready && cmd_go && !last) |=> xfer_valid && xfer_addr == $past(xfer_addr) + AW'(4)); // R4
  AST_BEAT_SIZE: assert property (@(posedge clk) disable iff (!rst_n) xfer_valid |-> xfer_bytes != 3'd0 && xfer_bytes <= 3'd4); // R5
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R6
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n) err |-> !xfer_valid); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!cmd_go && busy) |=> !busy && !desc_rd_req && !xfer_valid); // R8
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(xfer_write)); // R9
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n) !(desc_rd_req && xfer_valid)); // R2
endmodule

// File: tb/test_sg_dma_walker.sv
`timescale 1ns/1ps
module test_sg_dma_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_go = 1'b0;
  logic        cmd_to_mem = 1'b0;
  logic [31:0] tbl_base = '0;
  logic        desc_rd_req;
  logic [31:0] desc_rd_addr;
  logic        desc_rd_ack = 1'b0;
  logic [31:0] desc_rd_data = '0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [31:0] xfer_addr;
  logic [2:0]  xfer_bytes;
  logic        xfer_write;
  logic        busy, done, err;

  sg_dma_walker i_sg_dma_walker (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_to_mem(cmd_to_mem), .tbl_base(tbl_base),
    .desc_rd_req(desc_rd_req), .desc_rd_addr(desc_rd_addr), .desc_rd_ack(desc_rd_ack),
    .desc_rd_data(desc_rd_data), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes), .xfer_write(xfer_write),
    .busy(busy), .done(done), .err(err)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic ready_en = 1'b1;
  logic stall_on = 1'b0;
  logic [31:0] mem [logic [31:0]];
  logic [35:0] exp_beats [$];
  logic [31:0] exp_reads [$];

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic put_desc(input logic [31:0] ta, input logic [31:0] ra, input logic [15:0] len, input bit eot);
    mem[ta] = ra;
    mem[ta + 32'd4] = {eot, 15'd0, len};
    exp_reads.push_back(ta);
    exp_reads.push_back(ta + 32'd4);
  endtask

  task automatic push_region(input logic [31:0] ra, input logic [15:0] len, input bit wr);
    logic [31:0] a;
    int total;
    a = {ra[31:2], 2'b00};
    total = (len == 16'd0) ? 65536 : int'(len);
    while (total > 0) begin
      int b;
      b = (total >= 4) ? 4 : total;
      exp_beats.push_back({wr, 3'(b), a});
      a += 32'd4;
      total -= b;
    end
  endtask

  // Monitor and memory/line-buffer responder: values set here are consumed at the next rising edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      finish_run();
    end
    desc_rd_ack  = desc_rd_req && !(stall_on && cyc % 3 == 0);
    desc_rd_data = mem.exists(desc_rd_addr) ? mem[desc_rd_addr] : 32'd0;
    if (desc_rd_ack) begin
      if (exp_reads.size() == 0) check(1'b0, "R2/R3/R10 unexpected read", {4'd0, desc_rd_addr}, '0);
      else begin
        logic [31:0] e;
        e = exp_reads.pop_front();
        check(desc_rd_addr == e, "R2/R3 read address", {4'd0, desc_rd_addr}, {4'd0, e});
      end
    end
    xfer_ready = ready_en && !(stall_on && cyc % 4 == 1);
    if (xfer_valid && xfer_ready) begin
      if (exp_beats.size() == 0) check(1'b0, "R7 unexpected beat", {xfer_write, xfer_bytes, xfer_addr}, '0);
      else begin
        logic [35:0] e;
        e = exp_beats.pop_front();
        if ({xfer_write, xfer_bytes, xfer_addr} != e)
          check(1'b0, "R4/R5/R9 beat", {xfer_write, xfer_bytes, xfer_addr}, e);
        else if (exp_beats.size() % 1024 == 0) check(1'b1, "R4/R5 beat", '0, '0);
      end
    end
  end

  task automatic start_walk(input logic [31:0] base, input bit dir);
    @(negedge clk);
    cmd_go = 1'b0;
    @(negedge clk);
    tbl_base = base;
    cmd_to_mem = dir;
    cmd_go = 1'b1;
    @(negedge clk);
    check(busy && desc_rd_req, "R2 busy after start", {34'd0, busy, desc_rd_req}, 36'd3);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 70000 && busy; i++) @(negedge clk);
  endtask

  task automatic check_end(input bit exp_done, input bit exp_err, input string req);
    check(!busy && done == exp_done && err == exp_err, req, {33'd0, busy, done, err}, {34'd0, exp_done, exp_err});
    check(exp_beats.size() == 0 && exp_reads.size() == 0, req, 36'(exp_beats.size()), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !desc_rd_req && !xfer_valid, "R1 reset state",
          {31'd0, busy, done, err, desc_rd_req, xfer_valid}, '0);
    rst_n = 1'b1;
    stall_on = 1'b1;

    // Two regions, unaligned address bits, partial last beats, direction changed mid-walk (R4, R5, R9)
    put_desc(32'h0001_0000, 32'h2000_0102, 16'd10, 1'b0);
    put_desc(32'h0001_0008, 32'h3000_0000, 16'd7, 1'b1);
    push_region(32'h2000_0102, 16'd10, 1'b1);
    push_region(32'h3000_0000, 16'd7, 1'b1);
    start_walk(32'h0001_0003, 1'b1);
    repeat (3) @(negedge clk);
    cmd_to_mem = 1'b0;
    wait_idle();
    check_end(1'b1, 1'b0, "R6 end of table");

    // R10: command held high, no restart
    repeat (8) @(negedge clk);
    check(!busy && !desc_rd_req, "R10 no restart", {34'd0, busy, desc_rd_req}, '0);

    // R3: table pointer wraps inside its 64 KB window; R7 exact-fit region accepted
    put_desc(32'h0005_FFF8, 32'h4000_0010, 16'd5, 1'b0);
    put_desc(32'h0005_0000, 32'h4000_FFFC, 16'd4, 1'b1);
    push_region(32'h4000_0010, 16'd5, 1'b0);
    push_region(32'h4000_FFFC, 16'd4, 1'b0);
    start_walk(32'h0005_FFF8, 1'b0);
    wait_idle();
    check_end(1'b1, 1'b0, "R3/R7 wrap and exact fit");

    // R7: region overruns the boundary, done from the previous walk cleared (R6)
    put_desc(32'h0006_0000, 32'h4000_FFFC, 16'd8, 1'b1);
    start_walk(32'h0006_0000, 1'b1);
    wait_idle();
    check_end(1'b0, 1'b1, "R7 boundary crossing");

    // R5: zero length means 65536 bytes
    stall_on = 1'b0;
    put_desc(32'h0007_0000, 32'h5000_0000, 16'd0, 1'b1);
    push_region(32'h5000_0000, 16'd0, 1'b1);
    start_walk(32'h0007_0000, 1'b1);
    wait_idle();
    check_end(1'b1, 1'b0, "R5 zero length");

    // R8: abort while parked on a region
    @(posedge clk);
    #1 ready_en = 1'b0;
    put_desc(32'h0008_0000, 32'h6000_0000, 16'd64, 1'b1);
    start_walk(32'h0008_0000, 1'b0);
    for (int i = 0; i < 20 && !xfer_valid; i++) @(negedge clk);
    check(xfer_valid, "R8 parked on beat", {35'd0, xfer_valid}, 36'd1);
    cmd_go = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && !xfer_valid && !desc_rd_req, "R8 abort",
          {31'd0, busy, done, err, xfer_valid, desc_rd_req}, '0);
    check(exp_reads.size() == 0, "R8 reads", 36'(exp_reads.size()), '0);
    @(posedge clk);
    #1 ready_en = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule